// File: doc/BRIEF.md
# Hall Pattern Event Detector

This block watches the three Hall sensor lines of a brushless-DC motor and decides, at a chosen sampling moment, whether the rotor has advanced to the next commutation state, whether an input edge was only a glitch, or whether the sensors show an illegal step. The inputs are synchronised to the module clock. The sampling moment comes from one of seven hardware sources or from a software strike. An optional delay filter reloads a down-counter on each trigger and samples only once the count reaches 1. Glitches that settle back to the old pattern are then ignored.

Two copies of the pattern set are held. The active set holds the present Hall pattern, the next expected Hall pattern and the 6-bit drive pattern for the output stage. The shadow set is loaded through a write port. On a correct event the shadow set becomes active in the same cycle that the event flag is raised. A write with the strobe bit set makes the new shadow set active at once. Both event flags stay set until firmware clears them.

Top module: `hall_event_detector`

## Requirements
- R1: Each Hall input passes through a two-flop synchroniser. In bypass mode with edge triggering, a change on `hall_in` shows up on `good_flag` after the third rising clock edge and not earlier.
- R2: `trig_sel` picks the hardware trigger. 0 selects any change of the synchronised Hall pattern. Values 1 to 6 select `tmr_trig[0]` to `tmr_trig[5]`. 7 selects no hardware trigger. Any unselected source has no effect.
- R3: With the filter enabled (`bypass`=0), each hardware trigger reloads the delay counter with `dly_reload`, and a value of 0 loads as 1. The counter then steps down once per cycle, and the pattern is compared in the cycle where it holds 1. A trigger that arrives while the counter is running restarts the delay.
- R4: With `bypass`=1, the selected hardware trigger causes the comparison in the same cycle. The result is visible after the next rising edge.
- R5: A one-cycle pulse on `sw_trig` forces a comparison in that cycle, whatever the values of `bypass` and `trig_sel`.
- R6: If the compared pattern equals `cur_pat`, nothing changes: no flag is set and all active patterns hold.
- R7: If the compared pattern differs from `cur_pat` and equals `nxt_pat`, three things happen on the same edge. `good_flag` is set, `good_irq` pulses high for exactly one cycle, and the stored shadow current, next and drive patterns become active.
- R8: If the compared pattern matches neither `cur_pat` nor `nxt_pat`, `bad_flag` is set and the active patterns stay unchanged.
- R9: A write (`sh_wr`=1) with `sh_strobe`=1 loads the written current, next and drive patterns into the active registers on the next edge. This takes priority over a correct event in the same cycle.
- R10: `clr_good` and `clr_bad` clear their flags on the next edge. A flag being set in the same cycle wins over its clear.
- R11: After reset, all active patterns, both flags and the interrupt pulse are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Raw Hall sensor lines |
| tmr_trig | input | 6 | One-cycle timer event pulses, selected by `trig_sel` 1..6 |
| trig_sel | input | 3 | Hardware trigger source select |
| sw_trig | input | 1 | Software compare strike |
| bypass | input | 1 | 1 = skip the delay filter |
| dly_reload | input | 8 | Delay counter reload value |
| sh_wr | input | 1 | Shadow write strobe |
| sh_strobe | input | 1 | With `sh_wr`, make the written set active at once |
| sh_cur | input | 3 | Shadow current Hall pattern |
| sh_nxt | input | 3 | Shadow next expected Hall pattern |
| sh_drv | input | 6 | Shadow drive pattern |
| clr_good | input | 1 | Clear the correct-event flag |
| clr_bad | input | 1 | Clear the wrong-event flag |
| cur_pat | output | 3 | Active current Hall pattern |
| nxt_pat | output | 3 | Active next expected Hall pattern |
| drv_pat | output | 6 | Active drive pattern |
| good_flag | output | 1 | Correct-event flag, sticky |
| good_irq | output | 1 | One-cycle interrupt on a correct event |
| bad_flag | output | 1 | Wrong-event flag, sticky |

## Verification
Corrupted active or shadow state appears at the outputs on the edge that follows the next comparison. A correct event then copies the wrong drive pattern, and a spike raises a flag where none belongs. A delay counter that is off by one shifts that edge by a cycle. The bench sweeps every combination of current, next and sampled pattern. It also counts the latency from a Hall change to the flag exactly, both with the filter and without it, and detects a missing restart of the delay or a mis-routed trigger source within one cycle of the expected edge.

// File: rtl/hed_pkg.sv
package hed_pkg;
  localparam int HALL_W  = 3;
  localparam int DRV_W   = 6;
  localparam int DLY_W   = 8;
  localparam int TMR_N   = 6;
  localparam int SRC_N   = TMR_N + 1;
  localparam int SEL_W   = $clog2(SRC_N + 1);
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/hed_sync.sv
module hed_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         chg
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg  <= {stg[STAGES-2:0], din};
      prev <= stg[STAGES-1];
    end
  end

  assign dout = stg[STAGES-1];
  assign chg  = (stg[STAGES-1] != prev);
endmodule

// File: rtl/hed_filter.sv
module hed_filter #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_trig,
  input  logic             sw_trig,
  input  logic             bypass,
  input  logic [DLY_W-1:0] reload,
  output logic             go
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;
  logic             load;

  assign load = hw_trig && !bypass;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= (reload == '0) ? ONE : reload;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign go = sw_trig || (bypass && hw_trig) ||
              (!bypass && !hw_trig && cnt == ONE);

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == (($past(reload) == '0) ? ONE : $past(reload))));
  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  assert_sw_go_R5: assert property (@(posedge clk) disable iff (rst)
    sw_trig |-> go);
endmodule

// File: rtl/hed_compare.sv
module hed_compare #(
  parameter int HALL_W = 3,
  parameter int DRV_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [HALL_W-1:0] smp,
  input  logic              sh_wr,
  input  logic              sh_strobe,
  input  logic [HALL_W-1:0] sh_cur,
  input  logic [HALL_W-1:0] sh_nxt,
  input  logic [DRV_W-1:0]  sh_drv,
  input  logic              clr_good,
  input  logic              clr_bad,
  output logic [HALL_W-1:0] cur_pat,
  output logic [HALL_W-1:0] nxt_pat,
  output logic [DRV_W-1:0]  drv_pat,
  output logic              good_flag,
  output logic              good_irq,
  output logic              bad_flag
);
  logic [HALL_W-1:0] s_cur, s_nxt;
  logic [DRV_W-1:0]  s_drv;
  logic              hit_next, hit_none, now_load;

  assign hit_next = go && (smp != cur_pat) && (smp == nxt_pat);
  assign hit_none = go && (smp != cur_pat) && (smp != nxt_pat);
  assign now_load = sh_wr && sh_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cur     <= '0;
      s_nxt     <= '0;
      s_drv     <= '0;
      cur_pat   <= '0;
      nxt_pat   <= '0;
      drv_pat   <= '0;
      good_flag <= 1'b0;
      good_irq  <= 1'b0;
      bad_flag  <= 1'b0;
    end else begin
      good_irq <= hit_next;
      if (sh_wr) begin
        s_cur <= sh_cur;
        s_nxt <= sh_nxt;
        s_drv <= sh_drv;
      end
      if (hit_next)      good_flag <= 1'b1;
      else if (clr_good) good_flag <= 1'b0;
      if (hit_none)      bad_flag  <= 1'b1;
      else if (clr_bad)  bad_flag  <= 1'b0;
      if (now_load) begin
        cur_pat <= sh_cur;
        nxt_pat <= sh_nxt;
        drv_pat <= sh_drv;
      end else if (hit_next) begin
        cur_pat <= s_cur;
        nxt_pat <= s_nxt;
        drv_pat <= s_drv;
      end
    end
  end

  assert_spike_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (go && smp == cur_pat && !now_load && !clr_good && !clr_bad) |=>
      ($stable(cur_pat) && $stable(nxt_pat) && $stable(drv_pat) &&
       $stable(good_flag) && $stable(bad_flag)));
  assert_wrong_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (go && smp != cur_pat && smp != nxt_pat && !now_load) |=>
      (bad_flag && $stable(cur_pat) && $stable(drv_pat)));
  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    good_irq |-> good_flag);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (good_irq && !hit_next) |=> !good_irq);
  assert_strobe_load_R9: assert property (@(posedge clk) disable iff (rst)
    now_load |=> (cur_pat == $past(sh_cur) && drv_pat == $past(sh_drv)));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !($rose(good_flag) && $rose(bad_flag)));
endmodule

// File: rtl/hall_event_detector.sv
module hall_event_detector
  import hed_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [HALL_W-1:0] hall_in,
  input  logic [TMR_N-1:0]  tmr_trig,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              sw_trig,
  input  logic              bypass,
  input  logic [DLY_W-1:0]  dly_reload,
  input  logic              sh_wr,
  input  logic              sh_strobe,
  input  logic [HALL_W-1:0] sh_cur,
  input  logic [HALL_W-1:0] sh_nxt,
  input  logic [DRV_W-1:0]  sh_drv,
  input  logic              clr_good,
  input  logic              clr_bad,
  output logic [HALL_W-1:0] cur_pat,
  output logic [HALL_W-1:0] nxt_pat,
  output logic [DRV_W-1:0]  drv_pat,
  output logic              good_flag,
  output logic              good_irq,
  output logic              bad_flag
);
  logic [HALL_W-1:0] hall_s;
  logic              hall_chg, hw_trig, go;
  logic [SRC_N-1:0]  srcs;

  hed_sync #(.W(HALL_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(hall_in), .dout(hall_s), .chg(hall_chg)
  );

  assign srcs = {tmr_trig, hall_chg};

  always_comb begin
    hw_trig = 1'b0;
    if (int'(trig_sel) < SRC_N) hw_trig = srcs[trig_sel];
  end

  hed_filter #(.DLY_W(DLY_W)) u_filt (
    .clk(clk), .rst(rst), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .bypass(bypass), .reload(dly_reload), .go(go)
  );

  hed_compare #(.HALL_W(HALL_W), .DRV_W(DRV_W)) u_cmp (
    .clk(clk), .rst(rst), .go(go), .smp(hall_s),
    .sh_wr(sh_wr), .sh_strobe(sh_strobe),
    .sh_cur(sh_cur), .sh_nxt(sh_nxt), .sh_drv(sh_drv),
    .clr_good(clr_good), .clr_bad(clr_bad),
    .cur_pat(cur_pat), .nxt_pat(nxt_pat), .drv_pat(drv_pat),
    .good_flag(good_flag), .good_irq(good_irq), .bad_flag(bad_flag)
  );

  assert_no_sel7_trig_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(trig_sel) >= SRC_N) |-> !hw_trig);
endmodule

// File: tb/sim_hall_event_detector.sv
module sim_hall_event_detector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall_in = '0;
  logic [5:0] tmr_trig = '0;
  logic [2:0] trig_sel = 3'd7;
  logic       sw_trig = 0, bypass = 1, sh_wr = 0, sh_strobe = 0;
  logic [7:0] dly_reload = '0;
  logic [2:0] sh_cur = '0, sh_nxt = '0;
  logic [5:0] sh_drv = '0;
  logic       clr_good = 0, clr_bad = 0;
  logic [2:0] cur_pat, nxt_pat;
  logic [5:0] drv_pat;
  logic       good_flag, good_irq, bad_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hall_event_detector u0 (
    .clk(clk), .rst(rst), .hall_in(hall_in), .tmr_trig(tmr_trig),
    .trig_sel(trig_sel), .sw_trig(sw_trig), .bypass(bypass),
    .dly_reload(dly_reload), .sh_wr(sh_wr), .sh_strobe(sh_strobe),
    .sh_cur(sh_cur), .sh_nxt(sh_nxt), .sh_drv(sh_drv),
    .clr_good(clr_good), .clr_bad(clr_bad), .cur_pat(cur_pat),
    .nxt_pat(nxt_pat), .drv_pat(drv_pat), .good_flag(good_flag),
    .good_irq(good_irq), .bad_flag(bad_flag)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_sh(int c, int n, int d, bit strobe);
    sh_wr = 1; sh_strobe = strobe;
    sh_cur = 3'(c); sh_nxt = 3'(n); sh_drv = 6'(d);
    step(1);
    sh_wr = 0; sh_strobe = 0;
  endtask

  task automatic clr_all();
    clr_good = 1; clr_bad = 1;
    step(1);
    clr_good = 0; clr_bad = 0;
  endtask

  task automatic sw_pulse();
    sw_trig = 1;
    step(1);
    sw_trig = 0;
  endtask

  task automatic set_hall(int v);
    hall_in = 3'(v);
    step(4);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hv;
    step(3);
    rst = 0;
    step(1);
    check("R11 cur", int'(cur_pat), 0);
    check("R11 drv", int'(drv_pat), 0);
    check("R11 flags", int'({good_flag, good_irq, bad_flag}), 0);

    // R5 R6 R7 R8: exhaustive sweep with software strike
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 8; e++)
        for (int s = 0; s < 8; s++) begin
          int ec, en, ed, eg, eb;
          wr_sh(c, e, c * 8 + e, 1);
          wr_sh(s, s ^ 3, ((7 - s) * 8) + s, 0);
          set_hall(s);
          clr_all();
          sw_pulse();
          if (s == c) begin ec = c; en = e; ed = c * 8 + e; eg = 0; eb = 0; end
          else if (s == e) begin ec = s; en = s ^ 3; ed = (7 - s) * 8 + s; eg = 1; eb = 0; end
          else begin ec = c; en = e; ed = c * 8 + e; eg = 0; eb = 1; end
          check("R6/R7/R8 cur", int'(cur_pat), ec);
          check("R6/R7/R8 nxt", int'(nxt_pat), en);
          check("R6/R7/R8 drv", int'(drv_pat), ed);
          check("R7 good", int'(good_flag), eg);
          check("R7 irq", int'(good_irq), eg);
          check("R8 bad", int'(bad_flag), eb);
          if (eg == 1) begin
            step(1);
            check("R7 irq one cycle", int'(good_irq), 0);
          end
        end

    // R1 R4: latency, bypass, edge trigger
    trig_sel = 3'd7; bypass = 1;
    set_hall(0);
    wr_sh(0, 1, 5, 1);
    clr_all();
    trig_sel = 3'd0;
    hall_in = 3'd1;
    step(2);
    check("R1 not yet", int'(good_flag), 0);
    step(1);
    check("R1/R4 good after 3 edges", int'(good_flag), 1);

    // R3: filter delay 5
    trig_sel = 3'd7;
    wr_sh(1, 2, 9, 1);
    clr_all();
    trig_sel = 3'd0; bypass = 0; dly_reload = 8'd5;
    hall_in = 3'd2;
    step(7);
    check("R3 early", int'(good_flag), 0);
    step(1);
    check("R3 on time", int'(good_flag), 1);

    // R6: spike under filter
    wr_sh(2, 3, 4, 1);
    clr_all();
    hall_in = 3'd6;
    step(2);
    hall_in = 3'd2;
    step(20);
    check("R6 spike good", int'(good_flag), 0);
    check("R6 spike bad", int'(bad_flag), 0);
    check("R6 spike cur", int'(cur_pat), 2);

    // R3: retrigger restarts the delay
    wr_sh(2, 3, 4, 1);
    wr_sh(3, 4, 7, 0);
    clr_all();
    hall_in = 3'd5;
    step(3);
    hall_in = 3'd3;
    step(5);
    check("R3 restart early", int'(good_flag), 0);
    step(3);
    check("R3 restart on time", int'(good_flag), 1);
    check("R3 restart no bad", int'(bad_flag), 0);

    // R3: reload 0 acts as 1
    wr_sh(3, 4, 1, 1);
    clr_all();
    dly_reload = 8'd0;
    hall_in = 3'd4;
    step(3);
    check("R3 zero early", int'(good_flag), 0);
    step(1);
    check("R3 zero as one", int'(good_flag), 1);

    // R2: trigger source select sweep
    bypass = 1;
    hv = 4;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 6; k++) begin
        trig_sel = 3'd7;
        wr_sh(hv ^ 1, hv, 2, 1);
        clr_all();
        trig_sel = 3'(s);
        tmr_trig = 6'(1 << k);
        step(1);
        tmr_trig = '0;
        check("R2 source select", int'(good_flag), (s == k + 1) ? 1 : 0);
      end

    // R9: strobe write beats a correct event
    trig_sel = 3'd7;
    wr_sh(hv ^ 1, hv, 0, 1);
    clr_all();
    wr_sh(1, 2, 3, 0);
    sw_trig = 1; sh_wr = 1; sh_strobe = 1;
    sh_cur = 3'd4; sh_nxt = 3'd5; sh_drv = 6'd6;
    step(1);
    sw_trig = 0; sh_wr = 0; sh_strobe = 0;
    check("R9 cur", int'(cur_pat), 4);
    check("R9 nxt", int'(nxt_pat), 5);
    check("R9 drv", int'(drv_pat), 6);
    check("R9 good still set", int'(good_flag), 1);

    // R10: set wins over clear, then clear works
    wr_sh(hv ^ 1, hv ^ 2, 0, 1);
    clr_all();
    sw_trig = 1; clr_bad = 1;
    step(1);
    sw_trig = 0; clr_bad = 0;
    check("R10 set wins", int'(bad_flag), 1);
    clr_all();
    check("R10 bad cleared", int'(bad_flag), 0);
    check("R10 good cleared", int'(good_flag), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule